// File: doc/BRIEF.md
# Line-Doubled VGA Scanout Engine

This block produces the horizontal and vertical synchronisation pulses and an 8-bit pixel stream for a low-resolution framebuffer shown on a VGA-style monitor. A horizontal counter runs in the pixel clock domain and marks the end of every line. A line counter drives a four-state vertical machine. The states are `PH_BACK` (back porch), `PH_VIS` (visible), `PH_FRONT` (front porch) and `PH_SYNC` (vertical sync).

During visible lines the block reads one row of bytes from an external framebuffer memory. The memory takes an address and returns data one clock later. The bytes go straight to the pixel bus. Each framebuffer row is shown on two scanlines, because the row address only steps when the line count is even. The row address wraps back to the screen base when it runs past the end of the screen. Once a line's burst is over the pixel bus is held at zero, and it stays at zero on every porch and sync line.

All state decisions are made at the line boundary, using the incremented line count. The transitions are as follows:
- `BACK_TO_VIS` fires when the count reaches `VIS_START`.
- `VIS_TO_FRONT` fires at `FP_START`.
- `FRONT_TO_SYNC` fires at `VS_START`.
- `SYNC_TO_BACK` fires at `VS_END` and clears the count.
- Inside `PH_VIS`, `STEP_ROW` fires on an even count.

Top module: `vga_scan_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, hsync_n and vsync_n are 1, fb_rd_en is 0 and pix is 0. The vertical state is back porch with line count 0, so the first visible line starts VIS_START lines after reset.
- R2: Every line lasts H_TOTAL clocks, counted from h=0 at the line start. hsync_n is 0 exactly in the cycles with HS_BEGIN <= h < HS_FINISH.
- R3: The vertical states follow the order back porch, visible, front porch, sync, back porch, and the line count rises by one per line. A frame lasts exactly VS_END lines, so falling edges of vsync_n are VS_END*H_TOTAL clocks apart.
- R4: On a visible line, fb_rd_en is 1 for h = 0..LINE_LEN-1 with fb_rd_addr = row address + h. The byte returned for slot k appears on pix during h = k+1.
- R5: The first visible line (line count VIS_START) reads from row address SCREEN_BASE.
- R6: On each later visible line whose line count is even, the row address is the previous one plus LINE_LEN. On odd lines it is unchanged, so rows repeat on two scanlines.
- R7: An advanced row address that is at or beyond SCREEN_BASE+SCREEN_BYTES is replaced by SCREEN_BASE.
- R8: pix is 0 in every cycle that does not follow a read cycle: at h=0, for h > LINE_LEN, and on all non-visible lines. This holds whatever value fb_rd_data carries.
- R9: vsync_n is 0 exactly on lines with count VS_START..VS_END-1, starting at h=0 of the line with count VS_START.
- R10: fb_rd_en is 0 on back porch, front porch and sync lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_rd_en | output | 1 | Framebuffer read request for this cycle |
| fb_rd_addr | output | ADDR_W | Framebuffer byte address |
| fb_rd_data | input | PIX_W | Byte returned one clock after the request |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| pix | output | PIX_W | Pixel byte, zero outside bursts |

## Verification
The bench builds the engine with a 24-clock line, an 8-byte burst, hsync on clocks 12..15, visible lines 2..11, front porch to line 13, sync on lines 14..15, a base address of 0x100 and a 24-byte screen. These values make a frame only 384 clocks long, so whole frames and a mid-frame reset fit in a short run. The screen holds only three rows against ten visible lines, so row doubling and the wrap to the base address both occur inside every frame. The first visible line falls on an even count, so the first row is also shown twice. The memory model keeps returning its last non-zero byte when it is not read, which makes any gap in the pixel gating visible at the pixel bus.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

    typedef enum logic [1:0] {
        PH_BACK  = 2'd0,
        PH_VIS   = 2'd1,
        PH_FRONT = 2'd2,
        PH_SYNC  = 2'd3
    } vphase_e;

endpackage

// File: rtl/vga_hcount.sv
// Horizontal position counter with registered active-low sync pulse.
module vga_hcount #(
    parameter int H_TOTAL   = 800,
    parameter int HS_BEGIN  = 656,
    parameter int HS_FINISH = 752,
    parameter int HW        = $clog2(H_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] h_o,
    output logic          line_end_o,
    output logic          hsync_no
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] HS_LO  = HW'(HS_BEGIN);
    localparam logic [HW-1:0] HS_HI  = HW'(HS_FINISH);

    logic [HW-1:0] h_q;
    logic [HW-1:0] h_nxt;
    logic          hs_q;

    always_comb begin
        line_end_o = (h_q == H_LAST);
        h_nxt      = line_end_o ? '0 : h_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q  <= '0;
            hs_q <= 1'b1;
        end else begin
            h_q  <= h_nxt;
            hs_q <= !((h_nxt >= HS_LO) && (h_nxt < HS_HI));
        end
    end

    assign h_o      = h_q;
    assign hsync_no = hs_q;
endmodule

// File: rtl/vga_vphase.sv
// Vertical phase machine: line counter, phase register, vsync and row strobes.
module vga_vphase
    import vga_scan_pkg::*;
#(
    parameter int VIS_START = 34,
    parameter int FP_START  = 514,
    parameter int VS_START  = 523,
    parameter int VS_END    = 525,
    parameter int LW        = $clog2(VS_END + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end_i,
    output vphase_e       phase_o,
    output logic [LW-1:0] line_o,
    output logic          load_row_o,
    output logic          step_row_o,
    output logic          fetch_on_o,
    output logic          vsync_no
);
    localparam logic [LW-1:0] L_VIS = LW'(VIS_START);
    localparam logic [LW-1:0] L_FP  = LW'(FP_START);
    localparam logic [LW-1:0] L_VSS = LW'(VS_START);
    localparam logic [LW-1:0] L_VSE = LW'(VS_END);

    vphase_e       phase_q, phase_d;
    logic [LW-1:0] line_q, line_d;
    logic [LW-1:0] line_inc;
    logic          vs_q;

    assign line_inc = line_q + 1'b1;

    // Next-state logic: every decision is taken at the line boundary.
    always_comb begin
        phase_d    = phase_q;
        line_d     = line_q;
        load_row_o = 1'b0;
        step_row_o = 1'b0;
        if (line_end_i) begin
            line_d = line_inc;
            unique case (phase_q)
                PH_BACK: begin
                    if (line_inc >= L_VIS) begin       // BACK_TO_VIS
                        phase_d    = PH_VIS;
                        load_row_o = 1'b1;
                    end
                end
                PH_VIS: begin
                    if (line_inc >= L_FP) begin        // VIS_TO_FRONT
                        phase_d = PH_FRONT;
                    end else if (!line_inc[0]) begin   // STEP_ROW
                        step_row_o = 1'b1;
                    end
                end
                PH_FRONT: begin
                    if (line_inc >= L_VSS) begin       // FRONT_TO_SYNC
                        phase_d = PH_SYNC;
                    end
                end
                PH_SYNC: begin
                    if (line_inc >= L_VSE) begin       // SYNC_TO_BACK
                        phase_d = PH_BACK;
                        line_d  = '0;
                    end
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_BACK;
            line_q  <= '0;
        end else begin
            phase_q <= phase_d;
            line_q  <= line_d;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q <= 1'b1;
        end else begin
            vs_q <= (phase_d != PH_SYNC);
        end
    end

    assign phase_o    = phase_q;
    assign line_o     = line_q;
    assign fetch_on_o = (phase_q == PH_VIS);
    assign vsync_no   = vs_q;
endmodule

// File: rtl/vga_rowstep.sv
// Row start address: reload at the screen base, step by one line, wrap.
module vga_rowstep #(
    parameter int ADDR_W       = 16,
    parameter int SCREEN_BASE  = 0,
    parameter int SCREEN_BYTES = 38400,
    parameter int LINE_LEN     = 160
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] row_o
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SCREEN_BASE);
    localparam logic [ADDR_W:0]   LIMIT  = (ADDR_W + 1)'(SCREEN_BASE + SCREEN_BYTES);
    localparam logic [ADDR_W:0]   STRIDE = (ADDR_W + 1)'(LINE_LEN);

    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W:0]   row_sum;
    logic              wrap;

    always_comb begin
        row_sum = {1'b0, row_q} + STRIDE;
        wrap    = (row_sum >= LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            row_q <= BASE_A;
        end else if (step_i) begin
            row_q <= wrap ? BASE_A : row_sum[ADDR_W-1:0];
        end
    end

    assign row_o = row_q;
endmodule

// File: rtl/vga_pixgate.sv
// Burst address generation and pixel gating around the one-cycle memory read.
module vga_pixgate #(
    parameter int HW       = 10,
    parameter int ADDR_W   = 16,
    parameter int PIX_W    = 8,
    parameter int LINE_LEN = 160
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_on_i,
    input  logic [HW-1:0]     h_i,
    input  logic [ADDR_W-1:0] row_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [PIX_W-1:0]  rd_data_i,
    output logic [PIX_W-1:0]  pix_o
);
    localparam logic [HW-1:0] BURST = HW'(LINE_LEN);

    logic data_valid_q;

    assign rd_en_o   = fetch_on_i && (h_i < BURST);
    assign rd_addr_o = row_i + ADDR_W'(h_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_valid_q <= 1'b0;
        end else begin
            data_valid_q <= rd_en_o;
        end
    end

    assign pix_o = data_valid_q ? rd_data_i : '0;
endmodule

// File: rtl/vga_scan_engine.sv
module vga_scan_engine
    import vga_scan_pkg::*;
#(
    parameter int H_TOTAL      = 800,
    parameter int LINE_LEN     = 160,
    parameter int HS_BEGIN     = 656,
    parameter int HS_FINISH    = 752,
    parameter int VIS_START    = 34,
    parameter int FP_START     = 514,
    parameter int VS_START     = 523,
    parameter int VS_END       = 525,
    parameter int ADDR_W       = 16,
    parameter int PIX_W        = 8,
    parameter int SCREEN_BASE  = 0,
    parameter int SCREEN_BYTES = 38400
) (
    input  logic              clk,
    input  logic              rst,
    output logic              fb_rd_en,
    output logic [ADDR_W-1:0] fb_rd_addr,
    input  logic [PIX_W-1:0]  fb_rd_data,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic [PIX_W-1:0]  pix
);
    localparam int HW = $clog2(H_TOTAL);
    localparam int LW = $clog2(VS_END + 1);

    logic [HW-1:0]     h_cnt;
    logic              line_end;
    vphase_e           phase;
    logic [LW-1:0]     line_cnt;
    logic              load_row, step_row, fetch_on;
    logic [ADDR_W-1:0] row_addr;

    vga_hcount #(
        .H_TOTAL(H_TOTAL), .HS_BEGIN(HS_BEGIN), .HS_FINISH(HS_FINISH), .HW(HW)
    ) u_hcount (
        .clk(clk), .rst(rst), .h_o(h_cnt), .line_end_o(line_end), .hsync_no(hsync_n)
    );

    vga_vphase #(
        .VIS_START(VIS_START), .FP_START(FP_START), .VS_START(VS_START),
        .VS_END(VS_END), .LW(LW)
    ) u_vphase (
        .clk(clk), .rst(rst), .line_end_i(line_end), .phase_o(phase),
        .line_o(line_cnt), .load_row_o(load_row), .step_row_o(step_row),
        .fetch_on_o(fetch_on), .vsync_no(vsync_n)
    );

    vga_rowstep #(
        .ADDR_W(ADDR_W), .SCREEN_BASE(SCREEN_BASE),
        .SCREEN_BYTES(SCREEN_BYTES), .LINE_LEN(LINE_LEN)
    ) u_rowstep (
        .clk(clk), .rst(rst), .load_i(load_row), .step_i(step_row), .row_o(row_addr)
    );

    vga_pixgate #(
        .HW(HW), .ADDR_W(ADDR_W), .PIX_W(PIX_W), .LINE_LEN(LINE_LEN)
    ) u_pixgate (
        .clk(clk), .rst(rst), .fetch_on_i(fetch_on), .h_i(h_cnt), .row_i(row_addr),
        .rd_en_o(fb_rd_en), .rd_addr_o(fb_rd_addr), .rd_data_i(fb_rd_data), .pix_o(pix)
    );
endmodule

// File: rtl/vga_scan_chk.sv
module vga_scan_chk
    import vga_scan_pkg::*;
#(
    parameter int H_TOTAL      = 800,
    parameter int HS_BEGIN     = 656,
    parameter int HS_FINISH    = 752,
    parameter int VS_END       = 525,
    parameter int ADDR_W       = 16,
    parameter int PIX_W        = 8,
    parameter int SCREEN_BASE  = 0,
    parameter int SCREEN_BYTES = 38400,
    parameter int HW           = $clog2(H_TOTAL),
    parameter int LW           = $clog2(VS_END + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic              fb_rd_en,
    input logic [PIX_W-1:0]  pix,
    input logic [HW-1:0]     h_cnt,
    input logic              line_end,
    input vphase_e           phase,
    input logic [LW-1:0]     line_cnt,
    input logic [ADDR_W-1:0] row_addr
);
    a_r2_hsync_window: assert property (@(posedge clk) disable iff (rst)
        !hsync_n |-> (int'(h_cnt) >= HS_BEGIN) && (int'(h_cnt) < HS_FINISH));

    a_r3_phase_at_line_end: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(phase));

    a_r3_line_below_end: assert property (@(posedge clk) disable iff (rst)
        int'(line_cnt) < VS_END);

    a_r6_row_at_line_end: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(row_addr));

    a_r7_row_in_screen: assert property (@(posedge clk) disable iff (rst)
        (int'(row_addr) >= SCREEN_BASE) && (int'(row_addr) < SCREEN_BASE + SCREEN_BYTES));

    a_r8_pix_zero_after_burst: assert property (@(posedge clk) disable iff (rst)
        !fb_rd_en |=> (pix == '0));

    a_r9_vsync_tracks_sync: assert property (@(posedge clk) disable iff (rst)
        vsync_n == (phase != PH_SYNC));

    a_r10_fetch_only_visible: assert property (@(posedge clk) disable iff (rst)
        fb_rd_en |-> (phase == PH_VIS));
endmodule

bind vga_scan_engine vga_scan_chk #(
    .H_TOTAL(H_TOTAL), .HS_BEGIN(HS_BEGIN), .HS_FINISH(HS_FINISH), .VS_END(VS_END),
    .ADDR_W(ADDR_W), .PIX_W(PIX_W), .SCREEN_BASE(SCREEN_BASE),
    .SCREEN_BYTES(SCREEN_BYTES), .HW(HW), .LW(LW)
) u_chk (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n), .fb_rd_en(fb_rd_en),
    .pix(pix), .h_cnt(h_cnt), .line_end(line_end), .phase(phase),
    .line_cnt(line_cnt), .row_addr(row_addr)
);

// File: tb/vga_scan_engine_tb_top.sv
`timescale 1ns/1ps
module vga_scan_engine_tb_top;
    localparam int HT   = 24;
    localparam int LL   = 8;
    localparam int HSB  = 12;
    localparam int HSE  = 16;
    localparam int VIS  = 2;
    localparam int FP   = 12;
    localparam int VSS  = 14;
    localparam int VSE  = 16;
    localparam int AW   = 16;
    localparam int BASE = 'h100;
    localparam int SB   = 24;
    localparam int ROWS = SB / LL;

    typedef struct {
        bit    hs;
        bit    vs;
        bit    en;
        int    addr;
        int    px;
        string en_tag;
        string addr_tag;
        string px_tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fb_rd_en;
    logic [AW-1:0] fb_rd_addr;
    logic [7:0]    fb_rd_data = 8'hA5;
    logic          hsync_n, vsync_n;
    logic [7:0]    pix;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    vga_scan_engine #(
        .H_TOTAL(HT), .LINE_LEN(LL), .HS_BEGIN(HSB), .HS_FINISH(HSE),
        .VIS_START(VIS), .FP_START(FP), .VS_START(VSS), .VS_END(VSE),
        .ADDR_W(AW), .PIX_W(8), .SCREEN_BASE(BASE), .SCREEN_BYTES(SB)
    ) dut_i (
        .clk(clk), .rst(rst), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
        .fb_rd_data(fb_rd_data), .hsync_n(hsync_n), .vsync_n(vsync_n), .pix(pix)
    );

    function automatic int mem_byte(int a);
        return ((a * 37) + 5) & 8'hFF;
    endfunction

    // Framebuffer model: one-cycle read, holds the last byte otherwise.
    always @(posedge clk) begin
        if (fb_rd_en) fb_rd_data <= 8'(mem_byte(int'(fb_rd_addr)));
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver: pushes the expected outputs for cycles 0..ncyc-1 after reset release.
    task automatic push_run(int ncyc);
        for (int n = 0; n < ncyc; n++) begin
            exp_t e;
            int h, lc, k, row;
            bit vis;
            h   = n % HT;
            lc  = (n / HT) % VSE;
            vis = (lc >= VIS) && (lc < FP);
            k   = lc / 2 - VIS / 2;
            row = BASE + (k % ROWS) * LL;
            e.hs = !((h >= HSB) && (h < HSE));
            e.vs = !(lc >= VSS);
            e.en = vis && (h < LL);
            e.addr = row + h;
            e.px = (vis && h >= 1 && h <= LL) ? mem_byte(row + h - 1) : 0;
            e.en_tag   = vis ? "R4" : "R10";
            e.addr_tag = (lc == VIS) ? "R5" : ((k >= ROWS) ? "R7" : "R6");
            e.px_tag   = (e.px != 0 || vis && h >= 1 && h <= LL) ? "R4" : "R8";
            sb_q.push_back(e);
        end
    endtask

    // Monitor: pops one expected item per cycle, sampled after the falling edge.
    task automatic monitor_run();
        int n = 0;
        int last_fall = -1;
        bit prev_vs = 1'b1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(hsync_n == e.hs, "R2", "hsync_n", int'(hsync_n), int'(e.hs));
            check(vsync_n == e.vs, "R9", "vsync_n", int'(vsync_n), int'(e.vs));
            check(fb_rd_en == e.en, e.en_tag, "fb_rd_en", int'(fb_rd_en), int'(e.en));
            if (e.en)
                check(int'(fb_rd_addr) == e.addr, e.addr_tag, "fb_rd_addr",
                      int'(fb_rd_addr), e.addr);
            check(int'(pix) == e.px, e.px_tag, "pix", int'(pix), e.px);
            if (prev_vs && !vsync_n) begin
                if (last_fall >= 0)
                    check((n - last_fall) == VSE * HT, "R3", "frame period",
                          n - last_fall, VSE * HT);
                last_fall = n;
            end
            prev_vs = vsync_n;
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic check_reset_outputs();
        check(hsync_n == 1'b1, "R1", "reset hsync_n", int'(hsync_n), 1);
        check(vsync_n == 1'b1, "R1", "reset vsync_n", int'(vsync_n), 1);
        check(fb_rd_en == 1'b0, "R1", "reset fb_rd_en", int'(fb_rd_en), 0);
        check(pix == 8'h00, "R1", "reset pix", int'(pix), 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1 check_reset_outputs();
        rst = 1'b0;
        #1;
        // Two full frames plus part of a third: doubling, wrap and frame period.
        push_run(820);
        monitor_run();
        // Reset in the middle of a visible line.
        repeat (150) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); #1;
        check_reset_outputs();
        @(negedge clk);
        rst = 1'b0;
        #1;
        push_run(420);
        monitor_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule